// File: doc/BRIEF.md
# Debug Trigger Exact-Address Comparator

This block holds the compare value of one debug trigger on a 64-bit hart and reports when an access hits that value exactly. The compare value is not kept as a full 64-bit register. It is kept as the low physical-address bits plus a small tag that says how the upper bits are rebuilt. The tag can mean zero-extended, sign-extended, or a single fixed invalid marker. Every valid zero-extended physical address and every valid sign-extended virtual address can be held exactly. A written value that fits neither form is rewritten to the invalid marker.

The tag register works as a three-state machine. The states are `TAG_ZEXT` (upper bits rebuilt as zeros), `TAG_SEXT` (upper bits rebuilt as ones) and `TAG_INVAL` (the value reads as the marker). Every state has two transitions. A CSR write moves the machine to the state that the encoder picks for the written value. No write means the machine stays where it is. Reset enters `TAG_ZEXT` with the low bits cleared.

On each access, the effective address is compared against the value rebuilt from the register. When `acc_virt` is high, an address that is not a valid virtual address is first folded to the invalid marker. If `skip_bad_va` is also high, such an address is excluded from matching. The match output is registered.

Top module: `trig_addr_cmp`

## Requirements
- R1: After reset, `csr_rdata` reads 0 and `match` is low.
- R2: A written value whose bits 63..56 are all zero reads back unchanged on `csr_rdata` from the cycle after the write.
- R3: A written value whose bits 63..55 are all one reads back unchanged from the cycle after the write.
- R4: Any other written value reads back as 0x8000_0000_0000_0000 from the cycle after the write.
- R5: Without `csr_we`, `csr_rdata` holds its value.
- R6: With `acc_virt` low, the effective address is compared unchanged with the read-back value, and `match` follows on equality.
- R7: With `acc_virt` high, a valid virtual address is compared unchanged. An address is valid when bits 63..38 all equal bit 38.
- R8: With `acc_virt` high and `skip_bad_va` low, an invalid virtual address is compared as 0x8000_0000_0000_0000. It therefore matches only when the register reads back that marker.
- R9: With `acc_virt` high and `skip_bad_va` high, an invalid virtual address never matches. Valid addresses still match as in R7.
- R10: `match` is high for exactly the one cycle after an access with `acc_valid` high that compares equal. It is low after a cycle with `acc_valid` low.
- R11: When a write and an access fall in the same cycle, the access compares against the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Compare-register write strobe |
| csr_wdata | input | 64 | Value to write |
| csr_rdata | output | 64 | Rebuilt compare value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 64 | Effective address of the access |
| acc_virt | input | 1 | 1: address is virtual, 0: physical |
| skip_bad_va | input | 1 | 1: invalid virtual addresses never match |
| match | output | 1 | Registered match pulse |

## Verification
The sweep writes single-bit values and all-ones-above-a-bit values at every bit position. This exercises the boundaries between the zero-extended, sign-extended and marker forms. An encoder that is off by one bit would store an unrepresentable value as-is, or turn a legal value into the marker. Every stored form is then crossed with every address pattern, under both modes and both option settings. A fold applied in physical mode would make 0x8000_0000_0000_0000 match where it should not. A fold that ignores the option would let invalid virtual addresses hit. A directed case puts a write and an access in the same cycle. A design that compares against the newly written value would raise `match` wrongly in that case.

// File: rtl/tac_pkg.sv
package tac_pkg;
    typedef enum logic [1:0] {
        TAG_ZEXT  = 2'b00,
        TAG_SEXT  = 2'b01,
        TAG_INVAL = 2'b10
    } tag_e;
endpackage

// File: rtl/tac_encode.sv
module tac_encode
    import tac_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int PA_BITS = 56
) (
    input  logic [XLEN-1:0]    wdata,
    output tag_e               enc_tag,
    output logic [PA_BITS-1:0] enc_low
);
    localparam int HI = XLEN - PA_BITS;

    logic fits_zero;
    logic fits_ones;

    always_comb begin
        fits_zero = ~|wdata[XLEN-1:PA_BITS];
        fits_ones = &wdata[XLEN-1:PA_BITS-1];
        if (fits_zero) begin
            enc_tag = TAG_ZEXT;
            enc_low = wdata[PA_BITS-1:0];
        end else if (fits_ones) begin
            enc_tag = TAG_SEXT;
            enc_low = wdata[PA_BITS-1:0];
        end else begin
            enc_tag = TAG_INVAL;
            enc_low = '0;
        end
    end
    // HI is kept for readers; it documents the rebuilt width.
    localparam int UNUSED_HI = HI;
endmodule

// File: rtl/tac_decode.sv
module tac_decode
    import tac_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int PA_BITS = 56
) (
    input  tag_e               tag,
    input  logic [PA_BITS-1:0] low,
    output logic [XLEN-1:0]    value
);
    localparam int HI = XLEN - PA_BITS;
    localparam logic [XLEN-1:0] MARKER = {1'b1, {(XLEN-1){1'b0}}};

    always_comb begin
        unique case (tag)
            TAG_ZEXT:  value = {{HI{1'b0}}, low};
            TAG_SEXT:  value = {{HI{1'b1}}, low};
            TAG_INVAL: value = MARKER;
            default:   value = MARKER;
        endcase
    end
endmodule

// File: rtl/tac_fold.sv
module tac_fold #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 39
) (
    input  logic [XLEN-1:0] ea,
    input  logic            virt,
    input  logic            skip_bad,
    output logic [XLEN-1:0] cmp_addr,
    output logic            cmp_en
);
    localparam logic [XLEN-1:0] MARKER = {1'b1, {(XLEN-1){1'b0}}};

    logic va_ok;
    logic bad_va;

    always_comb begin
        va_ok    = (&ea[XLEN-1:VA_BITS-1]) | ~(|ea[XLEN-1:VA_BITS-1]);
        bad_va   = virt & ~va_ok;
        cmp_addr = bad_va ? MARKER : ea;
        cmp_en   = ~(bad_va & skip_bad);
    end
endmodule

// File: rtl/trig_addr_cmp.sv
module trig_addr_cmp
    import tac_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 39,
    parameter int PA_BITS = 56
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            acc_valid,
    input  logic [XLEN-1:0] acc_addr,
    input  logic            acc_virt,
    input  logic            skip_bad_va,
    output logic            match
);
    tag_e               state_q, state_d;
    logic [PA_BITS-1:0] low_q, low_d;
    tag_e               enc_tag;
    logic [PA_BITS-1:0] enc_low;
    logic [XLEN-1:0]    cmp_addr;
    logic               cmp_en;
    logic               match_d;

    tac_encode #(.XLEN(XLEN), .PA_BITS(PA_BITS)) i_enc (
        .wdata   (csr_wdata),
        .enc_tag (enc_tag),
        .enc_low (enc_low)
    );

    tac_decode #(.XLEN(XLEN), .PA_BITS(PA_BITS)) i_dec (
        .tag   (state_q),
        .low   (low_q),
        .value (csr_rdata)
    );

    tac_fold #(.XLEN(XLEN), .VA_BITS(VA_BITS)) i_fold (
        .ea       (acc_addr),
        .virt     (acc_virt),
        .skip_bad (skip_bad_va),
        .cmp_addr (cmp_addr),
        .cmp_en   (cmp_en)
    );

    // Next-state: every state leaves on a write to the encoded form.
    always_comb begin
        state_d = state_q;
        low_d   = low_q;
        unique case (state_q)
            TAG_ZEXT, TAG_SEXT, TAG_INVAL: begin
                if (csr_we) begin
                    state_d = enc_tag;
                    low_d   = enc_low;
                end
            end
            default: begin
                state_d = TAG_INVAL;
                low_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TAG_ZEXT;
            low_q   <= '0;
        end else begin
            state_q <= state_d;
            low_q   <= low_d;
        end
    end

    // Output: compare uses the value held before any same-cycle write.
    always_comb begin
        match_d = acc_valid & cmp_en & (cmp_addr == csr_rdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) match <= 1'b0;
        else        match <= match_d;
    end
endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 39,
    parameter int PA_BITS = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] csr_rdata,
    input logic            acc_valid,
    input logic [XLEN-1:0] acc_addr,
    input logic            acc_virt,
    input logic            skip_bad_va,
    input logic            match
);
    localparam logic [XLEN-1:0] MARKER = {1'b1, {(XLEN-1){1'b0}}};

    logic bad_va;
    assign bad_va = acc_virt &
        ~((&acc_addr[XLEN-1:VA_BITS-1]) | ~(|acc_addr[XLEN-1:VA_BITS-1]));

    p_zero_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && ~|csr_wdata[XLEN-1:PA_BITS]) |=> csr_rdata == $past(csr_wdata));

    p_ones_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && &csr_wdata[XLEN-1:PA_BITS-1]) |=> csr_rdata == $past(csr_wdata));

    p_marker_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && |csr_wdata[XLEN-1:PA_BITS] && !(&csr_wdata[XLEN-1:PA_BITS-1]))
        |=> csr_rdata == MARKER);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> $stable(csr_rdata));

    p_phys_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_virt) |=> match == ($past(acc_addr) == $past(csr_rdata)));

    p_skip_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && bad_va && skip_bad_va) |=> !match);

    p_bad_fold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && bad_va && !skip_bad_va) |=> match == ($past(csr_rdata) == MARKER));

    p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !match);
endmodule

bind trig_addr_cmp tac_checker #(.XLEN(XLEN), .VA_BITS(VA_BITS), .PA_BITS(PA_BITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_we      (csr_we),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .acc_virt    (acc_virt),
    .skip_bad_va (skip_bad_va),
    .match       (match)
);

// File: tb/test_trig_addr_cmp.sv
`timescale 1ns/1ps
module test_trig_addr_cmp;
    localparam logic [63:0] MARK = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        acc_valid = 1'b0;
    logic [63:0] acc_addr = '0;
    logic        acc_virt = 1'b0;
    logic        skip_bad_va = 1'b0;
    logic        match;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_addr_cmp i_trig_addr_cmp (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_virt(acc_virt), .skip_bad_va(skip_bad_va), .match(match)
    );

    function automatic logic [63:0] pat(int idx);
        if (idx < 64)       return 64'd1 << idx;
        else if (idx < 128) return ~64'd0 << (idx - 64);
        else if (idx == 128) return 64'd0;
        else if (idx == 129) return 64'h0000_003F_FFFF_FFFF;
        else                 return 64'h00FF_FFFF_FFFF_FFFF;
    endfunction

    function automatic logic [63:0] exp_read(logic [63:0] w);
        if (w[63:56] == 8'h00) return w;
        if (&w[63:55])         return w;
        return MARK;
    endfunction

    function automatic logic exp_match(logic [63:0] held, logic [63:0] ea,
                                       logic virt, logic skip);
        logic bad;
        bad = virt && !((&ea[63:38]) || !(|ea[63:38]));
        if (bad && skip) return 1'b0;
        return (bad ? MARK : ea) == held;
    endfunction

    task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(logic [63:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic acc(logic [63:0] ea, logic virt, logic skip, logic vld);
        @(negedge clk);
        acc_valid = vld; acc_addr = ea; acc_virt = virt; skip_bad_va = skip;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk64("R1 rdata after reset", csr_rdata, 64'd0);
        chk1("R1 match after reset", match, 1'b0);

        // R2 R3 R4: write sweep over boundary patterns
        for (int i = 0; i < 131; i++) begin
            logic [63:0] v;
            v = pat(i);
            wr(v);
            if (v[63:56] == 8'h00)      chk64("R2 zero-extended readback", csr_rdata, exp_read(v));
            else if (&v[63:55])         chk64("R3 sign-extended readback", csr_rdata, exp_read(v));
            else                        chk64("R4 marker readback", csr_rdata, exp_read(v));
        end

        // R5: idle cycles and accesses leave the register alone
        wr(64'h0000_1234_5678_9ABC);
        repeat (4) @(negedge clk);
        acc(64'h0, 1'b1, 1'b0, 1'b1);
        chk64("R5 hold without write", csr_rdata, 64'h0000_1234_5678_9ABC);

        // R6 R7 R8 R9: stored forms crossed with addresses, modes, option
        for (int s = 0; s < 8; s++) begin
            int sidx;
            case (s)
                0: sidx = 0;   1: sidx = 38;  2: sidx = 55;  3: sidx = 63;
                4: sidx = 102; 5: sidx = 119; 6: sidx = 74;  default: sidx = 128;
            endcase
            wr(pat(sidx));
            held = exp_read(pat(sidx));
            for (int a = 0; a < 131; a++) begin
                for (int m = 0; m < 4; m++) begin
                    logic virt, skip, bad;
                    logic [63:0] ea;
                    ea = pat(a);
                    virt = m[0]; skip = m[1];
                    bad = virt && !((&ea[63:38]) || !(|ea[63:38]));
                    acc(ea, virt, skip, 1'b1);
                    if (!virt)            chk1("R6 physical compare", match, exp_match(held, ea, virt, skip));
                    else if (!bad)        chk1("R7 valid virtual compare", match, exp_match(held, ea, virt, skip));
                    else if (!skip)       chk1("R8 folded invalid compare", match, exp_match(held, ea, virt, skip));
                    else                  chk1("R9 invalid excluded", match, 1'b0);
                end
            end
        end

        // R10: no access -> no pulse; pulse lasts one cycle
        wr(64'h0000_0000_0000_4000);
        acc(64'h0000_0000_0000_4000, 1'b0, 1'b0, 1'b0);
        chk1("R10 no pulse without valid", match, 1'b0);
        acc(64'h0000_0000_0000_4000, 1'b0, 1'b0, 1'b1);
        chk1("R10 pulse after hit", match, 1'b1);
        @(negedge clk);
        chk1("R10 pulse ends", match, 1'b0);

        // R11: write and access together compare against the old value
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = 64'h0000_0000_0000_8000;
        acc_valid = 1'b1; acc_addr = 64'h0000_0000_0000_4000; acc_virt = 1'b0;
        @(negedge clk);
        csr_we = 1'b0; acc_valid = 1'b0;
        chk1("R11 old value hit", match, 1'b1);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = 64'h0000_0000_0000_1000;
        acc_valid = 1'b1; acc_addr = 64'h0000_0000_0000_1000;
        @(negedge clk);
        csr_we = 1'b0; acc_valid = 1'b0;
        chk1("R11 new value not yet used", match, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule